// File: doc/BRIEF.md
# Serial Slot Personality Selector

This block governs one shared serial slot that can carry a UART, an SPI or an I2C engine. Software picks the active personality by writing a function code into an 8-bit select register. A code is taken only when the matching personality is built into the slot. The slot's build is fixed by a module parameter and appears as read-only presence bits. The selection can be frozen with a lock bit, and only a reset releases it. The slot's single interrupt line goes to the output of whichever personality is selected. When no valid personality is selected, the interrupt goes to none of them.

A separate pair of strobes controls a per-slot software reset. Both strobes carry a mask with one bit per slot, and this instance reacts only to its own bit. The set strobe puts the slot into reset. The clear strobe releases it. While the slot is held, the selection, lock and error flag are all cleared and register writes are ignored.

The control path is a three-state machine. ST_OPEN accepts selection writes. ST_LOCKED ignores them. ST_HELD is the software reset. The transitions are:
- OPEN_TO_LOCKED: an accepted write with the lock bit set.
- ANY_TO_HELD: a set strobe with this slot's mask bit, from any state.
- HELD_TO_OPEN: a clear strobe with this slot's bit and no set strobe in the same cycle.

Device reset returns the machine to ST_OPEN.

Top module: `sfs_top`

## Requirements
- R1: After device reset, the register reads back with selection 0, error 0 and lock 0. The slot is not in software reset and no personality interrupt is asserted.
- R2: Read-only presence bits sit at bit positions 4 (UART), 5 (SPI) and 6 (I2C), so the bit for code c is at position c+3. They always equal the PRESENT parameter, whatever is written.
- R3: In the open state, a write of function code bits [1:0] (0 none, 1 UART, 2 SPI, 3 I2C) whose personality is present, or code 0, sets the selection field bits [1:0] from the next cycle on.
- R4: In the open state, a write whose code names an absent personality leaves the selection unchanged and sets the sticky error flag at bit 3. Only a device reset or a slot software reset clears that flag.
- R5: An accepted write with lock bit 7 set stores the code and makes bit 7 read 1. After that, writes change neither the selection, nor the lock, nor the error flag.
- R6: A write with bit 7 set and an absent code is rejected as a whole: the slot is not locked and the error flag is set.
- R7: A set strobe whose mask has bit SLOT_IDX set raises slot_rst from the next cycle and clears selection, lock and error. Writes are ignored while the slot is held. A mask without bit SLOT_IDX has no effect.
- R8: A clear strobe with bit SLOT_IDX releases slot_rst on the next cycle, unless a set strobe for this slot arrives in the same cycle, in which case the set wins.
- R9: irq_in is forwarded combinationally to irq_uart, irq_spi or irq_i2c when the selection is 1, 2 or 3. With selection 0 every personality interrupt stays low, and at most one is ever high.
- R10: A device reset clears a set lock, so a new selection can be written afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset |
| reg_wr | input | 1 | Select register write strobe |
| reg_wdata | input | 8 | Write data: bits [1:0] code, bit 7 lock |
| reg_rdata | output | 8 | {lock, presence[2:0], error, 0, selection[1:0]} |
| rst_set_wr | input | 1 | Software reset set strobe |
| rst_clr_wr | input | 1 | Software reset clear strobe |
| rst_mask | input | NUM_SLOTS | Slot mask for the reset strobes |
| slot_rst | output | 1 | Slot held in software reset |
| irq_in | input | 1 | Slot's shared interrupt |
| irq_uart | output | 1 | Interrupt routed to the UART engine |
| irq_spi | output | 1 | Interrupt routed to the SPI engine |
| irq_i2c | output | 1 | Interrupt routed to the I2C engine |

## Verification
On every cycle, the assertions check the following:
- the presence field matches the build;
- interrupt routing stays one-hot or silent and follows the selection;
- a locked selection holds steady until a slot reset;
- a rejected write leaves the selection alone and sets the error flag;
- a held slot reads fully cleared.

The bench sweeps every ordered pair of codes, with and without the lock bit, against a build that lacks one personality. Only those scenarios show that code 0 is always accepted, that the error flag stays set across later good writes, that a clear strobe loses to a simultaneous set, and that a device reset lifts the lock.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [1:0] {
        FN_NONE = 2'd0,
        FN_UART = 2'd1,
        FN_SPI  = 2'd2,
        FN_I2C  = 2'd3
    } func_code_e;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_HELD   = 2'd2
    } slot_state_e;

    localparam int REG_W        = 8;
    localparam int NUM_FUNCS    = 3;
    localparam int CODE_W       = 2;
    localparam int ERR_BIT      = 3;
    localparam int PRES_LSB     = 4;
    localparam int LOCK_BIT     = 7;

endpackage

// File: rtl/sfs_ctrl_fsm.sv
module sfs_ctrl_fsm
    import sfs_pkg::*;
#(
    parameter logic [NUM_FUNCS-1:0] PRESENT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_lock,
    input  logic              set_hit,
    input  logic              clr_hit,
    output logic [CODE_W-1:0] sel,
    output logic              err,
    output logic              locked,
    output logic              held
);

    // Code 0 is always legal; code c maps to presence bit c-1.
    localparam logic [NUM_FUNCS:0] LEGAL = {PRESENT, 1'b1};

    slot_state_e state_q, state_d;
    logic        code_ok;

    assign code_ok = LEGAL[wr_code];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (set_hit)
                    state_d = ST_HELD;
                else if (wr_en && wr_lock && code_ok)
                    state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (set_hit)
                    state_d = ST_HELD;
            end
            ST_HELD: begin
                if (clr_hit && !set_hit)
                    state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OPEN;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= FN_NONE;
            err <= 1'b0;
        end else if (set_hit) begin
            sel <= FN_NONE;
            err <= 1'b0;
        end else if (state_q == ST_OPEN && wr_en) begin
            if (code_ok)
                sel <= wr_code;
            else
                err <= 1'b1;
        end
    end

    assign locked = (state_q == ST_LOCKED);
    assign held   = (state_q == ST_HELD);

endmodule

// File: rtl/sfs_irq_route.sv
module sfs_irq_route
    import sfs_pkg::*;
(
    input  logic                 irq_in,
    input  logic [CODE_W-1:0]    sel,
    output logic [NUM_FUNCS-1:0] irq_out
);

    for (genvar g = 0; g < NUM_FUNCS; g++) begin : g_route
        assign irq_out[g] = irq_in && (sel == CODE_W'(g + 1));
    end

endmodule

// File: rtl/sfs_top.sv
module sfs_top
    import sfs_pkg::*;
#(
    parameter int                   NUM_SLOTS = 4,
    parameter int                   SLOT_IDX  = 0,
    parameter logic [NUM_FUNCS-1:0] PRESENT   = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 rst_set_wr,
    input  logic                 rst_clr_wr,
    input  logic [NUM_SLOTS-1:0] rst_mask,
    output logic                 slot_rst,
    input  logic                 irq_in,
    output logic                 irq_uart,
    output logic                 irq_spi,
    output logic                 irq_i2c
);

    logic [CODE_W-1:0]    sel;
    logic                 err;
    logic                 locked;
    logic [NUM_FUNCS-1:0] irq_vec;
    logic                 set_hit;
    logic                 clr_hit;

    assign set_hit = rst_set_wr && rst_mask[SLOT_IDX];
    assign clr_hit = rst_clr_wr && rst_mask[SLOT_IDX];

    sfs_ctrl_fsm #(.PRESENT(PRESENT)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_code (reg_wdata[CODE_W-1:0]),
        .wr_lock (reg_wdata[LOCK_BIT]),
        .set_hit (set_hit),
        .clr_hit (clr_hit),
        .sel     (sel),
        .err     (err),
        .locked  (locked),
        .held    (slot_rst)
    );

    sfs_irq_route route_i (
        .irq_in  (irq_in),
        .sel     (sel),
        .irq_out (irq_vec)
    );

    assign irq_uart = irq_vec[FN_UART - 1];
    assign irq_spi  = irq_vec[FN_SPI - 1];
    assign irq_i2c  = irq_vec[FN_I2C - 1];

    always_comb begin
        reg_rdata                                 = '0;
        reg_rdata[CODE_W-1:0]                     = sel;
        reg_rdata[ERR_BIT]                        = err;
        reg_rdata[PRES_LSB +: NUM_FUNCS]          = PRESENT;
        reg_rdata[LOCK_BIT]                       = locked;
    end

endmodule

// File: rtl/sfs_top_chk.sv
module sfs_top_chk
    import sfs_pkg::*;
#(
    parameter int                   NUM_SLOTS = 4,
    parameter int                   SLOT_IDX  = 0,
    parameter logic [NUM_FUNCS-1:0] PRESENT   = '1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [REG_W-1:0]     reg_rdata,
    input logic                 rst_set_wr,
    input logic                 rst_clr_wr,
    input logic [NUM_SLOTS-1:0] rst_mask,
    input logic                 slot_rst,
    input logic                 irq_in,
    input logic                 irq_uart,
    input logic                 irq_spi,
    input logic                 irq_i2c
);

    logic [NUM_FUNCS:0] legal_chk;
    logic               absent_wr;
    logic               set_chk;

    assign legal_chk = {PRESENT, 1'b1};
    assign absent_wr = reg_wr && !legal_chk[reg_wdata[CODE_W-1:0]];
    assign set_chk   = rst_set_wr && rst_mask[SLOT_IDX];

    assert_presence_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[PRES_LSB +: NUM_FUNCS] == PRESENT);

    assert_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (absent_wr && !slot_rst && !reg_rdata[LOCK_BIT] && !set_chk)
        |=> (reg_rdata[ERR_BIT] && $stable(reg_rdata[CODE_W-1:0])));

    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[LOCK_BIT] && !set_chk)
        |=> (reg_rdata[LOCK_BIT] && $stable(reg_rdata[CODE_W-1:0])));

    assert_held_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rst |-> (reg_rdata[CODE_W-1:0] == 2'd0 && !reg_rdata[LOCK_BIT]
                      && !reg_rdata[ERR_BIT]));

    assert_set_enters_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_chk |=> slot_rst);

    assert_irq_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_i2c, irq_spi, irq_uart}));

    assert_irq_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[CODE_W-1:0] == 2'd0) |-> !(irq_uart || irq_spi || irq_i2c));

    assert_irq_uart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in && reg_rdata[CODE_W-1:0] == 2'd1) |-> irq_uart);

endmodule

bind sfs_top sfs_top_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_IDX  (SLOT_IDX),
    .PRESENT   (PRESENT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .rst_set_wr (rst_set_wr),
    .rst_clr_wr (rst_clr_wr),
    .rst_mask   (rst_mask),
    .slot_rst   (slot_rst),
    .irq_in     (irq_in),
    .irq_uart   (irq_uart),
    .irq_spi    (irq_spi),
    .irq_i2c    (irq_i2c)
);

// File: tb/sfs_top_tb_top.sv
`timescale 1ns/1ps
module sfs_top_tb_top;

    localparam int         NSLOT = 4;
    localparam int         SIDX  = 2;
    localparam logic [2:0] PRES  = 3'b011; // UART and SPI built, no I2C

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic             rst_set_wr = 1'b0;
    logic             rst_clr_wr = 1'b0;
    logic [NSLOT-1:0] rst_mask = '0;
    logic             slot_rst;
    logic             irq_in = 1'b0;
    logic             irq_uart, irq_spi, irq_i2c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sfs_top #(.NUM_SLOTS(NSLOT), .SLOT_IDX(SIDX), .PRESENT(PRES)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rst_set_wr(rst_set_wr), .rst_clr_wr(rst_clr_wr),
        .rst_mask(rst_mask), .slot_rst(slot_rst), .irq_in(irq_in),
        .irq_uart(irq_uart), .irq_spi(irq_spi), .irq_i2c(irq_i2c)
    );

    // Reference state built from the requirements
    int m_sel, m_err, m_lock;

    function automatic bit legal(int c);
        return (c == 0) || PRES[c-1];
    endfunction

    function automatic int exp_rd();
        return m_lock * 128 + int'(PRES) * 16 + m_err * 8 + m_sel;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic dev_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_sel = 0; m_err = 0; m_lock = 0;
    endtask

    task automatic wr_reg(input int code, input bit lock);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = {lock, 5'b0, 2'(code)};
        @(negedge clk);
        reg_wr = 1'b0;
        if (m_lock == 0) begin
            if (legal(code)) begin
                m_sel = code;
                if (lock) m_lock = 1;
            end else begin
                m_err = 1;
            end
        end
    endtask

    task automatic strobe(input bit s, input bit c, input int mask);
        @(negedge clk);
        rst_set_wr = s; rst_clr_wr = c; rst_mask = NSLOT'(mask);
        @(negedge clk);
        rst_set_wr = 1'b0; rst_clr_wr = 1'b0; rst_mask = '0;
    endtask

    task automatic chk_irq(string req);
        int ex;
        irq_in = 1'b1; #0.5;
        ex = (m_sel == 0) ? 0 : (1 << (m_sel - 1));
        chk(req, {irq_i2c, irq_spi, irq_uart}, ex);
        irq_in = 1'b0; #0.5;
        chk(req, {irq_i2c, irq_spi, irq_uart}, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_sel = 0; m_err = 0; m_lock = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R2: reset state and presence field
        chk("R1 rdata", reg_rdata, exp_rd());
        chk("R1 slot_rst", slot_rst, 0);
        chk("R2 presence", reg_rdata[6:4], PRES);
        chk_irq("R1 irq");

        // R3, R4, R9: every ordered pair of unlocked writes
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                dev_reset();
                wr_reg(a, 1'b0);
                chk("R3_R4 first", reg_rdata, exp_rd());
                chk_irq("R9 route");
                wr_reg(b, 1'b0);
                chk("R3_R4 second", reg_rdata, exp_rd());
                chk_irq("R9 route");
            end
        end

        // R5, R6: lock attempt with each code, then every follow-up code
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                dev_reset();
                wr_reg(a, 1'b1);
                chk("R5_R6 lock", reg_rdata, exp_rd());
                wr_reg(b, 1'b1);
                chk("R5_R6 after", reg_rdata, exp_rd());
                chk_irq("R9 locked");
            end
        end

        // R7: other slot's mask bit has no effect
        dev_reset();
        wr_reg(2, 1'b1);
        strobe(1'b1, 1'b0, 'hF & ~(1 << SIDX));
        chk("R7 other mask", slot_rst, 0);
        chk("R7 other mask rd", reg_rdata, exp_rd());
        // R7: own bit holds the slot and clears everything
        strobe(1'b1, 1'b0, 1 << SIDX);
        m_sel = 0; m_err = 0; m_lock = 0;
        chk("R7 held", slot_rst, 1);
        chk("R7 cleared", reg_rdata, exp_rd());
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h01;
        @(negedge clk); reg_wr = 1'b0;
        chk("R7 write ignored", reg_rdata, exp_rd());
        chk_irq("R7 irq");
        // R8: set wins over clear in the same cycle
        strobe(1'b1, 1'b1, 1 << SIDX);
        chk("R8 set wins", slot_rst, 1);
        strobe(1'b0, 1'b1, 'hF & ~(1 << SIDX));
        chk("R8 other clr", slot_rst, 0 + 1);
        strobe(1'b0, 1'b1, 1 << SIDX);
        chk("R8 released", slot_rst, 0);
        wr_reg(1, 1'b0);
        chk("R8 write after", reg_rdata, exp_rd());
        // R4 error clears on slot reset
        wr_reg(3, 1'b0);
        chk("R4 sticky", reg_rdata, exp_rd());
        strobe(1'b1, 1'b0, 1 << SIDX);
        strobe(1'b0, 1'b1, 1 << SIDX);
        m_sel = 0; m_err = 0;
        chk("R4 err cleared by slot reset", reg_rdata, exp_rd());

        // R10: device reset lifts the lock
        wr_reg(1, 1'b1);
        chk("R10 locked", reg_rdata[7], 1);
        dev_reset();
        chk("R10 unlocked", reg_rdata, exp_rd());
        wr_reg(2, 1'b0);
        chk("R10 new select", reg_rdata, exp_rd());

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule